// File: doc/BRIEF.md
# Multi-Class Interrupt Concentrator with Periodic Timers

This block gathers interrupt requests of three kinds and steers them to a set of output interrupt lines, one line per target core. The three kinds are level-sensitive external lines, software mailboxes that any bus master raises by writing a word, and internal down-counting periodic timers. Every output owns one mask per kind. Masks are changed only through separate set ports and clear ports, so one bus write touches only the bits written as 1. Masks can be read back.

Each output also has a packed status word. One read of it reports, for all three kinds at once, whether an enabled request is pending and which source was chosen. Within a kind, the lowest-numbered enabled pending source wins.

All registers sit behind a simple word-addressed bus. The word address is a 4-bit function code above a 5-bit slot number. The slot is the output number, the mailbox number or the timer number, depending on the function. Software normally writes all ones to every clear port at start-up. It then opens mask bits, reads the status word on an interrupt, and acknowledges through the mailbox read or the timer acknowledge read.

Top module: `irq_concentrator`

## Requirements
- R1: The word address is `{code[3:0], slot[4:0]}`. The codes are: 0 mailbox data, 1 timer period (read/write), 2 timer acknowledge (read), 3/4/5 read the line/mailbox/timer mask, 6/7 set/clear the line mask, 8/9 set/clear the mailbox mask, 10/11 set/clear the timer mask, 12 read the status word. A period written to one timer slot reads back from that slot only.
- R2: A write to a set port ORs the written data into the addressed output's mask of that kind. All other bits stay unchanged.
- R3: A write to a clear port clears the mask bits written as 1. All other bits stay unchanged.
- R4: A mask read returns the current mask zero-extended to 32 bits. Mask bits at or above the number of sources of that kind read as 0. All read data appears on the port the cycle after the read strobe and holds until the next read.
- R5: A write to mailbox slot N stores the word and makes mailbox N pending.
- R6: A read of mailbox slot N returns the stored word and clears mailbox N pending.
- R7: A timer with period P>0 raises its pending flag exactly P clock edges after the edge that wrote P, and every P edges after that. A period of 0 stops the timer.
- R8: A timer acknowledge read returns the pending flag in bit 0 and clears it. A new expiry on the same edge wins over the clear.
- R9: In the status word, bit 0, bit 1 and bit 2 flag an enabled pending timer, line and mailbox. Bits 12:8, 20:16 and 28:24 hold the chosen timer, line and mailbox number.
- R10: Within each kind the lowest-numbered enabled pending source is chosen. Every other status bit, including the number field of a kind with nothing pending, reads 0.
- R11: Output line N is high when any source of any kind is both pending and enabled in output N's mask. It follows a mask write or a line input without a register stage.
- R12: After reset all masks, mailbox flags, periods and timer flags are 0, and every output line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe (never together with wrEn) |
| addr | input | 9 | Word address: function code in 8:5, slot in 4:0 |
| wrData | input | 32 | Bus write data |
| rdData | output | 32 | Bus read data, registered |
| hwLines | input | NUM_HW | Level-sensitive external request lines |
| irq | output | NUM_OUT | One interrupt line per output |

## Verification
Mask writes, mailbox accesses and acknowledges take effect at the edge that samples the strobe. The output lines react combinationally, so the bench checks them at the falling edge that follows that edge. Read data is captured at the strobe edge and sampled at the next falling edge. Timer checks count rising edges from the period-write edge: the line must still be low after P-1 edges and high after P. After an acknowledge, the next expiry is counted from the reload edge and not from the read.

// File: rtl/irq_conc_pkg.sv
package irq_conc_pkg;
  localparam int SLOT_W = 5;
  localparam int CODE_W = 4;
  localparam int ADDR_W = CODE_W + SLOT_W;
  localparam int DATA_W = 32;

  typedef enum logic [CODE_W-1:0] {
    FN_BOX      = 4'd0,
    FN_PERIOD   = 4'd1,
    FN_TACK     = 4'd2,
    FN_MRD_HW   = 4'd3,
    FN_MRD_SW   = 4'd4,
    FN_MRD_TM   = 4'd5,
    FN_MSET_HW  = 4'd6,
    FN_MCLR_HW  = 4'd7,
    FN_MSET_SW  = 4'd8,
    FN_MCLR_SW  = 4'd9,
    FN_MSET_TM  = 4'd10,
    FN_MCLR_TM  = 4'd11,
    FN_STATUS   = 4'd12
  } funcE;

  typedef enum logic [1:0] {CL_HW = 2'd0, CL_SW = 2'd1, CL_TM = 2'd2} classE;

  typedef struct packed {
    logic              boxWr;
    logic              boxRd;
    logic              perWr;
    logic              perRd;
    logic              ackRd;
    logic              maskSet;
    logic              maskClr;
    logic              maskRd;
    logic              statRd;
    classE             cls;
    logic [SLOT_W-1:0] slot;
  } strobeT;

  // lowest set bit position of a 32-bit vector, 0 when empty
  function automatic logic [SLOT_W-1:0] lowIdx(input logic [DATA_W-1:0] v);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (v[i]) r = SLOT_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_conc_ctrl.sv
module irq_conc_ctrl
  import irq_conc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobeT            stb
);
  always_comb begin
    stb      = '0;
    stb.slot = addr[SLOT_W-1:0];
    case (funcE'(addr[ADDR_W-1:SLOT_W]))
      FN_BOX:     begin stb.boxWr = wrEn; stb.boxRd = rdEn; end
      FN_PERIOD:  begin stb.perWr = wrEn; stb.perRd = rdEn; end
      FN_TACK:    stb.ackRd = rdEn;
      FN_MRD_HW:  begin stb.maskRd = rdEn; stb.cls = CL_HW; end
      FN_MRD_SW:  begin stb.maskRd = rdEn; stb.cls = CL_SW; end
      FN_MRD_TM:  begin stb.maskRd = rdEn; stb.cls = CL_TM; end
      FN_MSET_HW: begin stb.maskSet = wrEn; stb.cls = CL_HW; end
      FN_MCLR_HW: begin stb.maskClr = wrEn; stb.cls = CL_HW; end
      FN_MSET_SW: begin stb.maskSet = wrEn; stb.cls = CL_SW; end
      FN_MCLR_SW: begin stb.maskClr = wrEn; stb.cls = CL_SW; end
      FN_MSET_TM: begin stb.maskSet = wrEn; stb.cls = CL_TM; end
      FN_MCLR_TM: begin stb.maskClr = wrEn; stb.cls = CL_TM; end
      FN_STATUS:  stb.statRd = rdEn;
      default:    ;
    endcase
  end

  // R1: a single bus access decodes to at most one operation
  assert_single_op_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn) |-> $onehot0({stb.boxWr, stb.boxRd, stb.perWr, stb.perRd,
                                  stb.ackRd, stb.maskSet, stb.maskClr,
                                  stb.maskRd, stb.statRd}));
endmodule

// File: rtl/irq_conc_mask.sv
module irq_conc_mask #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         setEn,
  input  logic         clrEn,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rstN)      q <= '0;
    else if (setEn) q <= q | bits;
    else if (clrEn) q <= q & ~bits;
  end

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    setEn |=> (q & $past(bits)) == $past(bits));
  assert_set_keeps_R2: assert property (@(posedge clk) disable iff (!rstN)
    setEn |=> (q & ~$past(bits)) == ($past(q) & ~$past(bits)));
  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clrEn && !setEn) |=> (q & $past(bits)) == '0);
  assert_clr_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clrEn && !setEn) |=> (q & ~$past(bits)) == ($past(q) & ~$past(bits)));
endmodule

// File: rtl/irq_conc_timer.sv
module irq_conc_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             ackClr,
  output logic [CNT_W-1:0] period,
  output logic             pend
);
  logic [CNT_W-1:0] count;
  logic             fire;

  assign fire = !loadEn && (period != '0) && (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      period <= '0;
      count  <= '0;
      pend   <= 1'b0;
    end else begin
      if (loadEn) begin
        period <= loadVal;
        count  <= loadVal;
      end else if (period != '0) begin
        count <= fire ? period : count - CNT_W'(1);
      end
      if (fire)        pend <= 1'b1;
      else if (ackClr) pend <= 1'b0;
    end
  end

  assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (period == '0 && !loadEn && !pend) |=> !pend);
  assert_expiry_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> pend);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackClr && !fire) |=> !pend);
endmodule

// File: rtl/irq_conc_datapath.sv
module irq_conc_datapath
  import irq_conc_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_HW  = 8,
  parameter int NUM_SW  = 8,
  parameter int NUM_TM  = 4,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_HW-1:0]  hwLines,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_OUT-1:0] irq
);
  logic [NUM_HW-1:0] maskHw [NUM_OUT];
  logic [NUM_SW-1:0] maskSw [NUM_OUT];
  logic [NUM_TM-1:0] maskTm [NUM_OUT];
  logic [DATA_W-1:0] statWord [NUM_OUT];
  logic [DATA_W-1:0] boxVal [NUM_SW];
  logic [NUM_SW-1:0] boxPend;
  logic [CNT_W-1:0]  perVal [NUM_TM];
  logic [NUM_TM-1:0] tmPend;
  logic [DATA_W-1:0] rdNext;
  logic              rdAny;

  // mailboxes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      boxPend <= '0;
      for (int i = 0; i < NUM_SW; i++) boxVal[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SW; i++) begin
        if (stb.boxWr && stb.slot == SLOT_W'(i)) begin
          boxVal[i]  <= wrData;
          boxPend[i] <= 1'b1;
        end else if (stb.boxRd && stb.slot == SLOT_W'(i)) begin
          boxPend[i] <= 1'b0;
        end
      end
    end
  end

  // timers
  for (genvar t = 0; t < NUM_TM; t++) begin : gTm
    irq_conc_timer #(.CNT_W(CNT_W)) uTm (
      .clk    (clk),
      .rstN   (rstN),
      .loadEn (stb.perWr && stb.slot == SLOT_W'(t)),
      .loadVal(wrData[CNT_W-1:0]),
      .ackClr (stb.ackRd && stb.slot == SLOT_W'(t)),
      .period (perVal[t]),
      .pend   (tmPend[t])
    );
  end

  // per-output masks, selection and line
  for (genvar o = 0; o < NUM_OUT; o++) begin : gOut
    logic hitOut;
    logic [DATA_W-1:0] hwAct, swAct, tmAct;
    assign hitOut = stb.slot == SLOT_W'(o);

    irq_conc_mask #(.W(NUM_HW)) uMaskHw (
      .clk(clk), .rstN(rstN),
      .setEn(stb.maskSet && stb.cls == CL_HW && hitOut),
      .clrEn(stb.maskClr && stb.cls == CL_HW && hitOut),
      .bits(wrData[NUM_HW-1:0]), .q(maskHw[o]));
    irq_conc_mask #(.W(NUM_SW)) uMaskSw (
      .clk(clk), .rstN(rstN),
      .setEn(stb.maskSet && stb.cls == CL_SW && hitOut),
      .clrEn(stb.maskClr && stb.cls == CL_SW && hitOut),
      .bits(wrData[NUM_SW-1:0]), .q(maskSw[o]));
    irq_conc_mask #(.W(NUM_TM)) uMaskTm (
      .clk(clk), .rstN(rstN),
      .setEn(stb.maskSet && stb.cls == CL_TM && hitOut),
      .clrEn(stb.maskClr && stb.cls == CL_TM && hitOut),
      .bits(wrData[NUM_TM-1:0]), .q(maskTm[o]));

    assign hwAct = DATA_W'(hwLines & maskHw[o]);
    assign swAct = DATA_W'(boxPend & maskSw[o]);
    assign tmAct = DATA_W'(tmPend & maskTm[o]);

    assign statWord[o] = {3'b000, lowIdx(swAct), 3'b000, lowIdx(hwAct),
                          3'b000, lowIdx(tmAct), 5'b00000,
                          |swAct, |hwAct, |tmAct};
    assign irq[o] = |{hwAct, swAct, tmAct};

    // R11: a line never rises while every mask of that output is empty
    assert_line_needs_mask_R11: assert property (@(posedge clk) disable iff (!rstN)
      (maskHw[o] == '0 && maskSw[o] == '0 && maskTm[o] == '0) |-> !irq[o]);
  end

  // read multiplexer
  assign rdAny = stb.boxRd | stb.perRd | stb.ackRd | stb.maskRd | stb.statRd;

  always_comb begin
    rdNext = '0;
    if (stb.boxRd) begin
      for (int i = 0; i < NUM_SW; i++)
        if (stb.slot == SLOT_W'(i)) rdNext = boxVal[i];
    end
    if (stb.perRd || stb.ackRd) begin
      for (int t = 0; t < NUM_TM; t++)
        if (stb.slot == SLOT_W'(t))
          rdNext = stb.perRd ? DATA_W'(perVal[t]) : DATA_W'(tmPend[t]);
    end
    if (stb.maskRd) begin
      for (int o = 0; o < NUM_OUT; o++) begin
        if (stb.slot == SLOT_W'(o)) begin
          case (stb.cls)
            CL_HW:   rdNext = DATA_W'(maskHw[o]);
            CL_SW:   rdNext = DATA_W'(maskSw[o]);
            default: rdNext = DATA_W'(maskTm[o]);
          endcase
        end
      end
    end
    if (stb.statRd) begin
      for (int o = 0; o < NUM_OUT; o++)
        if (stb.slot == SLOT_W'(o)) rdNext = statWord[o];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      rdData <= '0;
    else if (rdAny) rdData <= rdNext;
  end

  for (genvar i = 0; i < NUM_SW; i++) begin : gBoxChk
    assert_box_write_R5: assert property (@(posedge clk) disable iff (!rstN)
      (stb.boxWr && stb.slot == SLOT_W'(i)) |=> boxPend[i]);
    assert_box_read_R6: assert property (@(posedge clk) disable iff (!rstN)
      (stb.boxRd && !stb.boxWr && stb.slot == SLOT_W'(i)) |=> !boxPend[i]);
  end

  assert_read_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdAny |=> $stable(rdData));
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
  import irq_conc_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_HW  = 8,
  parameter int NUM_SW  = 8,
  parameter int NUM_TM  = 4,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [8:0]         addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_HW-1:0]  hwLines,
  output logic [NUM_OUT-1:0] irq
);
  strobeT stb;

  irq_conc_ctrl uCtrl (
    .clk (clk),
    .rstN(rstN),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .stb (stb)
  );

  irq_conc_datapath #(
    .NUM_OUT(NUM_OUT), .NUM_HW(NUM_HW), .NUM_SW(NUM_SW),
    .NUM_TM(NUM_TM), .CNT_W(CNT_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .hwLines(hwLines),
    .rdData (rdData),
    .irq    (irq)
  );
endmodule

// File: tb/irq_concentrator_test.sv
`timescale 1ns/1ps
module irq_concentrator_test;
  localparam int NUM_OUT = 4;
  localparam int NUM_HW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NUM_HW-1:0] hwLines = '0;
  logic [NUM_OUT-1:0] irq;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_concentrator uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .hwLines(hwLines), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input int code, input int slot, input logic [31:0] d);
    @(negedge clk);
    addr = {4'(code), 5'(slot)};
    wrData = d;
    wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic busRd(input int code, input int slot, output logic [31:0] d);
    @(negedge clk);
    addr = {4'(code), 5'(slot)};
    rdEn = 1'b1;
    @(posedge clk);
    #1 rdEn = 1'b0;
    @(negedge clk);
    d = rdData;
  endtask

  function automatic logic [31:0] expStat(bit tmV, int tmI, bit hwV, int hwI, bit swV, int swI);
    return {3'b0, 5'(swI), 3'b0, 5'(hwI), 3'b0, 5'(tmI), 5'b0, swV, hwV, tmV};
  endfunction

  task automatic closeAll();
    for (int o = 0; o < NUM_OUT; o++) begin
      busWr(7, o, 32'hFFFF_FFFF);
      busWr(9, o, 32'hFFFF_FFFF);
      busWr(11, o, 32'hFFFF_FFFF);
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    @(negedge clk);
    check("R12 lines low", 32'(irq), 32'h0);
    busRd(3, 0, d); check("R12 line mask", d, 32'h0);
    busRd(4, 1, d); check("R12 mailbox mask", d, 32'h0);
    busRd(5, 2, d); check("R12 timer mask", d, 32'h0);
    busRd(12, 0, d); check("R12 status", d, 32'h0);
    busRd(1, 0, d); check("R12 period", d, 32'h0);
  endtask

  task automatic testMasks();
    logic [31:0] d;
    busWr(6, 1, 32'h0000_00F0);
    busRd(3, 1, d); check("R2 set F0", d, 32'h0000_00F0);
    busWr(6, 1, 32'h0000_000F);
    busRd(3, 1, d); check("R2 set keeps others", d, 32'h0000_00FF);
    busWr(7, 1, 32'h0000_003C);
    busRd(3, 1, d); check("R3 clear subset", d, 32'h0000_00C3);
    busRd(3, 0, d); check("R2 other output untouched", d, 32'h0);
    busWr(8, 3, 32'hFFFF_FFFF);
    busRd(4, 3, d); check("R4 unused mask bits zero", d, 32'h0000_00FF);
    busWr(10, 3, 32'h0000_0005);
    busRd(5, 3, d); check("R4 timer mask readback", d, 32'h0000_0005);
    closeAll();
    busRd(3, 1, d); check("R3 clear all", d, 32'h0);
  endtask

  task automatic testMailbox();
    logic [31:0] d;
    busWr(0, 3, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R11 masked mailbox silent", 32'(irq), 32'h0);
    busWr(8, 0, 32'h0000_0008);
    @(negedge clk);
    check("R11 enabled mailbox drives line", 32'(irq), 32'h1);
    busRd(12, 0, d); check("R9 mailbox status", d, expStat(0, 0, 0, 0, 1, 3));
    busRd(0, 3, d); check("R6 mailbox data", d, 32'hDEAD_BEEF);
    check("R6 read clears pending", 32'(irq), 32'h0);
    busRd(12, 0, d); check("R10 empty status", d, 32'h0);
    closeAll();
  endtask

  task automatic testPriority();
    logic [31:0] d;
    @(negedge clk);
    hwLines = 8'h28;
    busWr(6, 2, 32'h0000_00FF);
    busWr(0, 6, 32'h1111_1111);
    busWr(0, 2, 32'h2222_2222);
    busWr(8, 2, 32'h0000_0040);
    busRd(12, 2, d); check("R10 lowest line and masked mailbox", d, expStat(0, 0, 1, 3, 1, 6));
    check("R11 only output 2 active", 32'(irq), 32'h4);
    busWr(8, 2, 32'h0000_0004);
    busRd(12, 2, d); check("R10 lower mailbox wins", d, expStat(0, 0, 1, 3, 1, 2));
    busWr(7, 2, 32'h0000_0008);
    busRd(12, 2, d); check("R9 next line after clear", d, expStat(0, 0, 1, 5, 1, 2));
    busRd(0, 6, d); check("R5 mailbox 6 stored", d, 32'h1111_1111);
    busRd(0, 2, d); check("R5 mailbox 2 stored", d, 32'h2222_2222);
    @(negedge clk);
    hwLines = '0;
    @(negedge clk);
    check("R11 line follows input", 32'(irq), 32'h0);
    closeAll();
  endtask

  task automatic testTimer();
    logic [31:0] d;
    busWr(1, 3, 32'd77);
    busRd(1, 3, d); check("R1 period readback", d, 32'd77);
    busRd(1, 2, d); check("R1 neighbour slot untouched", d, 32'd0);
    busWr(1, 3, 32'd0);
    busWr(10, 0, 32'h0000_0002);
    busWr(1, 1, 32'd5);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R7 not yet at P-1 edges", 32'(irq), 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R7 expiry after P edges", 32'(irq), 32'h1);
    busRd(2, 1, d); check("R8 ack returns flag", d, 32'h1);
    check("R8 ack clears", 32'(irq), 32'h0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 reload not yet", 32'(irq), 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R7 periodic expiry", 32'(irq), 32'h1);
    busRd(12, 0, d); check("R9 timer status", d, expStat(1, 1, 0, 0, 0, 0));
    busWr(1, 1, 32'd0);
    busRd(2, 1, d); check("R8 ack flag before stop", d, 32'h1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R7 zero period stops", 32'(irq), 32'h0);
    busRd(2, 1, d); check("R8 nothing pending", d, 32'h0);
    closeAll();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    closeAll();
    testMasks();
    testMailbox();
    testPriority();
    testTimer();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule